// File: doc/BRIEF.md
# Successive Approximation Conversion Sequencer

This block runs the digital half of a successive-approximation converter. A one-cycle start request, accepted only while the block is idle, freezes the analog sampler by raising `hold`. In the same step it clears the approximation register and starts an internal bit clock. On each bit-clock tick one bit of the code is decided from a single comparator input, working from the most significant bit downwards. The code under test is presented on `trial_code` for the external DAC. Two conversion lengths are available. A full cycle resolves all 12 bits. A short cycle resolves only the upper 8 bits and leaves the low 4 bits of the result at zero.

When the final bit is decided, the block drops `hold` so the sampler can acquire again. It transfers the code to `result`, pulses `eoc` and raises `data_ready`. It then keeps `busy` high for a further acquisition interval. The result can therefore be read before the status flag falls. A start request that arrives while `busy` is high is discarded. The bit-clock divide ratio and the acquisition interval are parameters counted in system-clock cycles.

Top module: `sar_sequencer`

## Requirements
- R1: A start request sampled while idle causes `hold` and `busy` to be high from the next clock edge, with `trial_code` equal to 0x800 (only bit 11 set) and the approximation cleared.
- R2: Bits are decided one per bit clock of CLK_DIV system cycles, in order from bit 11 down to the last bit; after the first decision `trial_code` holds the decided bit 11 plus bit 10 set.
- R3: A trial bit is kept when `comp_lt` is 1 at its decision edge (the DAC sum lies below the input) and is cleared otherwise, so a comparator with `comp_lt = (trial_code <= X)` yields a result of exactly X.
- R4: If `short_cycle` is 1 when the start is accepted, only bits 11 to 4 are decided (8 bit clocks), result bits 3 to 0 are 0, and later changes of `short_cycle` do not alter the running conversion.
- R5: A start request while `busy` is high is ignored: it changes neither the result nor the cycle on which `busy` falls.
- R6: On the edge that registers the final decision, `hold` falls, `result` takes the new code, `data_ready` rises and `eoc` is high for exactly one cycle.
- R7: `busy` falls exactly ACQ_CYCLES clock cycles after `data_ready` rises; ACQ_CYCLES is at least 1.
- R8: While a conversion runs, `result` keeps the value of the previous conversion.
- R9: After reset, `hold`, `busy`, `eoc`, `data_ready`, `result` and `trial_code` are all 0.
- R10: `data_ready` clears on the edge that accepts a new start and stays high after `busy` falls until then.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Conversion request, sampled on the rising edge |
| short_cycle | input | 1 | Selects the 8-bit cycle when sampled with an accepted start |
| comp_lt | input | 1 | Comparator: 1 when the DAC sum is below the held input |
| trial_code | output | 12 | Code driven to the DAC during conversion, 0 otherwise |
| result | output | 12 | Last completed conversion result |
| hold | output | 1 | Sampler hold command, high while bits are being decided |
| busy | output | 1 | Status, high from start until the acquisition interval ends |
| eoc | output | 1 | One-cycle pulse when the final bit is registered |
| data_ready | output | 1 | High from completion until the next accepted start |

## Verification
On every cycle the embedded properties check several rules. `hold` never stands without `busy`, and `eoc` never lasts two cycles. `result` changes only alongside `eoc`. A start during hold cannot end the busy period. Each decision moves the bit pointer down by exactly one, and a short conversion ends with zero low bits. `busy` can only fall while data is valid and the sampler is released. Timing and value matters need the directed scenarios with a modelled comparator. These cover the exact decision count per mode and the code produced for chosen inputs, including all-zero and all-one. They also cover the latching of the short-cycle selection, the precise acquisition length, and the preservation of the previous result during a new conversion.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CONV = 2'd1,
    ST_ACQ  = 2'd2
  } seq_state_t;
endpackage

// File: rtl/sar_bit_clock.sv
module sar_bit_clock #(
  parameter int CLK_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic run,
  output logic tick
);
  localparam int DIV_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLK_DIV - 1);

  logic [DIV_W-1:0] cnt_q, cnt_d;

  assign tick = run && (cnt_q == DIV_LAST);

  always_comb begin
    cnt_d = cnt_q;
    if (restart)   cnt_d = '0;
    else if (tick) cnt_d = '0;
    else if (run)  cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  a_r2_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !restart) |=> !tick || (CLK_DIV == 1));
endmodule

// File: rtl/sar_approx_reg.sv
module sar_approx_reg #(
  parameter int RES_W   = 12,
  parameter int SHORT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             short_in,
  input  logic             step,
  input  logic             comp_lt,
  output logic [RES_W-1:0] trial,
  output logic [RES_W-1:0] decided,
  output logic             last_bit,
  output logic             short_mode
);
  localparam int IDX_W = $clog2(RES_W);
  localparam logic [IDX_W-1:0] IDX_TOP  = IDX_W'(RES_W - 1);
  localparam logic [IDX_W-1:0] IDX_SHRT = IDX_W'(RES_W - SHORT_W);

  logic [RES_W-1:0] sar_q, sar_d;
  logic [IDX_W-1:0] ptr_q, ptr_d;
  logic             short_q, short_d;
  logic [RES_W-1:0] bit_mask;

  assign bit_mask   = RES_W'(1) << ptr_q;
  assign trial      = sar_q | bit_mask;
  assign decided    = comp_lt ? (sar_q | bit_mask) : sar_q;
  assign last_bit   = (ptr_q == (short_q ? IDX_SHRT : '0));
  assign short_mode = short_q;

  always_comb begin
    sar_d   = sar_q;
    ptr_d   = ptr_q;
    short_d = short_q;
    if (clear) begin
      sar_d   = '0;
      ptr_d   = IDX_TOP;
      short_d = short_in;
    end else if (step) begin
      sar_d = decided;
      if (!last_bit) ptr_d = ptr_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sar_q   <= '0;
      ptr_q   <= '0;
      short_q <= 1'b0;
    end else begin
      sar_q   <= sar_d;
      ptr_q   <= ptr_d;
      short_q <= short_d;
    end
  end

  // R2: each decision moves exactly one bit down
  a_r2_ptr_descends: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !clear && !last_bit) |=> (ptr_q == $past(ptr_q) - 1'b1));
  // R4: short mode stays fixed between starts
  a_r4_short_latched: assert property (@(posedge clk) disable iff (!rst_n)
    !clear |=> $stable(short_q));
endmodule

// File: rtl/sar_acq_timer.sv
module sar_acq_timer #(
  parameter int ACQ_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic run,
  output logic expired
);
  localparam int CNT_W = (ACQ_CYCLES > 1) ? $clog2(ACQ_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_INIT = CNT_W'(ACQ_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign expired = run && (cnt_q == '0);

  always_comb begin
    cnt_d = cnt_q;
    if (load)                     cnt_d = CNT_INIT;
    else if (run && cnt_q != '0)  cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  initial begin
    a_r7_acq_min: assert (ACQ_CYCLES >= 1);
  end
endmodule

// File: rtl/sar_sequencer.sv
module sar_sequencer
  import sar_seq_pkg::*;
#(
  parameter int RES_W      = 12,
  parameter int SHORT_W    = 8,
  parameter int CLK_DIV    = 4,
  parameter int ACQ_CYCLES = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             short_cycle,
  input  logic             comp_lt,
  output logic [RES_W-1:0] trial_code,
  output logic [RES_W-1:0] result,
  output logic             hold,
  output logic             busy,
  output logic             eoc,
  output logic             data_ready
);
  localparam int LOW_W = RES_W - SHORT_W;

  seq_state_t       state_q, state_d;
  logic             accept, tick, finish, acq_done;
  logic             last_bit, short_mode;
  logic [RES_W-1:0] trial, decided;
  logic [RES_W-1:0] result_q, result_d;
  logic             eoc_q, eoc_d, rdy_q, rdy_d;

  assign accept = (state_q == ST_IDLE) && start;
  assign finish = (state_q == ST_CONV) && tick && last_bit;

  sar_bit_clock #(.CLK_DIV(CLK_DIV)) u_bitclk (
    .clk(clk), .rst_n(rst_n), .restart(accept),
    .run(state_q == ST_CONV), .tick(tick)
  );

  sar_approx_reg #(.RES_W(RES_W), .SHORT_W(SHORT_W)) u_sar (
    .clk(clk), .rst_n(rst_n), .clear(accept), .short_in(short_cycle),
    .step(tick), .comp_lt(comp_lt), .trial(trial), .decided(decided),
    .last_bit(last_bit), .short_mode(short_mode)
  );

  sar_acq_timer #(.ACQ_CYCLES(ACQ_CYCLES)) u_acq (
    .clk(clk), .rst_n(rst_n), .load(finish),
    .run(state_q == ST_ACQ), .expired(acq_done)
  );

  always_comb begin
    state_d  = state_q;
    result_d = result_q;
    eoc_d    = 1'b0;
    rdy_d    = rdy_q;
    case (state_q)
      ST_IDLE: if (start) begin
        state_d = ST_CONV;
        rdy_d   = 1'b0;
      end
      ST_CONV: if (finish) begin
        state_d  = ST_ACQ;
        result_d = decided;
        eoc_d    = 1'b1;
        rdy_d    = 1'b1;
      end
      ST_ACQ: if (acq_done) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      result_q <= '0;
      eoc_q    <= 1'b0;
      rdy_q    <= 1'b0;
    end else begin
      state_q  <= state_d;
      result_q <= result_d;
      eoc_q    <= eoc_d;
      rdy_q    <= rdy_d;
    end
  end

  assign hold       = (state_q == ST_CONV);
  assign busy       = (state_q != ST_IDLE);
  assign trial_code = hold ? trial : '0;
  assign result     = result_q;
  assign eoc        = eoc_q;
  assign data_ready = rdy_q;

  a_r1_first_trial: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold) |-> (trial_code == (RES_W'(1) << (RES_W - 1))));
  a_r5_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && start) |=> busy);
  a_r6_hold_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
    hold |-> busy);
  a_r6_eoc_single: assert property (@(posedge clk) disable iff (!rst_n)
    eoc |=> !eoc);
  a_r8_result_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(result) |-> eoc);
  a_r4_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (eoc && short_mode) |-> (result[LOW_W-1:0] == '0));
  a_r7_ready_first: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (data_ready && !hold));
endmodule

// File: tb/tb_sar_sequencer.sv
module tb_sar_sequencer;
  localparam int RES_W = 12;
  localparam int DIV   = 4;
  localparam int ACQ   = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic short_cycle = 1'b0;
  logic comp_lt;
  logic [RES_W-1:0] trial_code, result, target;
  logic hold, busy, eoc, data_ready;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  // comparator model: DAC below (or at) the input keeps the bit
  assign comp_lt = (trial_code <= target);

  sar_sequencer #(.RES_W(RES_W), .SHORT_W(8), .CLK_DIV(DIV), .ACQ_CYCLES(ACQ)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .short_cycle(short_cycle),
    .comp_lt(comp_lt), .trial_code(trial_code), .result(result),
    .hold(hold), .busy(busy), .eoc(eoc), .data_ready(data_ready)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // mode 0 plain, 1 flip short_cycle mid-run, 2 extra starts while busy
  task automatic convert(input logic [11:0] tgt, input bit sc, input int mode, input logic [11:0] prev);
    int nb;
    logic [11:0] exp_res;
    nb = sc ? 8 : 12;
    exp_res = sc ? (tgt & 12'hFF0) : tgt;
    target = tgt;
    short_cycle = sc;
    start = 1'b1;
    cyc(1);
    start = 1'b0;
    chk(hold && busy, "R1 hold/busy", {hold, busy}, 2'b11);
    chk(trial_code == 12'h800, "R1 first trial", trial_code, 12'h800);
    chk(!data_ready, "R10 ready cleared", data_ready, 0);
    chk(result == prev, "R8 old result", result, prev);
    cyc(DIV);
    chk(trial_code == ((tgt & 12'h800) | 12'h400), "R2 second trial",
        trial_code, (tgt & 12'h800) | 12'h400);
    if (mode == 1) short_cycle = ~sc;
    if (mode == 2) begin
      start = 1'b1;
      cyc(1);
      start = 1'b0;
      cyc(nb * DIV - DIV - 2);
    end else begin
      cyc(nb * DIV - DIV - 1);
    end
    chk(hold && !eoc, "R2 still deciding", {hold, eoc}, 2'b10);
    chk(result == prev, "R8 held during run", result, prev);
    cyc(1);
    chk(eoc && data_ready && !hold, "R6 completion", {eoc, data_ready, hold}, 3'b110);
    chk(result == exp_res, sc ? "R4 short result" : "R3 result", result, exp_res);
    cyc(1);
    chk(!eoc, "R6 eoc one cycle", eoc, 0);
    if (mode == 2) begin
      start = 1'b1;
      cyc(1);
      start = 1'b0;
      cyc(ACQ - 3);
    end else begin
      cyc(ACQ - 2);
    end
    chk(busy, "R7 busy in acquisition", busy, 1);
    cyc(1);
    chk(!busy, "R7 busy falls on time", busy, 0);
    chk(data_ready && result == exp_res, "R10 ready after busy", {data_ready, result}, {1'b1, exp_res});
    cyc(3);
    if (mode == 2) chk(!busy, "R5 ignored start", busy, 0);
  endtask

  task automatic t_reset();
    chk(!hold && !busy && !eoc && !data_ready, "R9 flags", {hold, busy, eoc, data_ready}, 0);
    chk(result == 0 && trial_code == 0, "R9 codes", {result, trial_code}, 0);
  endtask

  initial begin
    target = '0;
    cyc(3);
    rst_n = 1'b1;
    cyc(2);
    t_reset();
    convert(12'hA5C, 1'b0, 0, 12'h000);
    convert(12'hFFF, 1'b0, 0, 12'hA5C);
    convert(12'h000, 1'b0, 0, 12'hFFF);
    convert(12'h7E9, 1'b1, 1, 12'h000);
    convert(12'h3C7, 1'b0, 1, 12'h7E0);
    convert(12'h5A5, 1'b0, 2, 12'h3C7);
    convert(12'h91F, 1'b1, 2, 12'h5A5);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule